// File: doc/BRIEF.md
# Serial Wiper Register with High-Active Select

This block is the digital front end of a 256-position digital potentiometer. A host writes a wiper code over three wires: a serial clock, a serial data line and a select line that is active high. All three inputs are asynchronous to the block. Each passes through a short synchronizer into a fast system clock domain. Edges of the serial clock and of the select line are then found by comparing successive synchronized samples.

While select is high, each rising serial clock edge moves one data bit into an input shift register, most significant bit first. When select falls, the shift register is copied into the wiper register. The copy happens only if a full word arrived in that window. A one-cycle pulse marks each copy. The wiper register comes out of reset at midscale. It drives the wiper code output and a one-hot tap select with one line per ladder position. Code 0 selects the tap at the low end of the ladder. The all-ones code selects the tap one step below the high end.

The system clock must run at least four times faster than the serial clock. Each serial clock phase must then last at least two system cycles.

Top module: `hsel_wiper_ctrl`

## Requirements
- R1: After reset the wiper code is 0x80, tap select has only bit 128 set, and no update pulse is present.
- R2: While select is high, each rising serial clock edge shifts in one data bit. The word is 8 bits, sent most significant bit first. Once select falls after exactly 8 such edges, the wiper code equals that word.
- R3: The wiper code changes only after select falls. While select stays high it keeps its previous value, even when 8 or more bits have arrived.
- R4: When a select window holds more than 8 rising edges, the earliest bits are discarded. The committed code is made of the last 8 bits shifted in.
- R5: When a select window holds fewer than 8 rising edges, the wiper code is unchanged after select falls and no update pulse occurs.
- R6: Rising serial clock edges while select is low change nothing. The wiper code stays the same, and these edges do not count toward the 8 bits that the next select window needs.
- R7: The update pulse is high for exactly one system cycle per commit. That cycle is the first cycle in which the wiper code shows the new value.
- R8: Tap select always has exactly one bit set, and the index of that bit equals the wiper code. Code 0x00 sets bit 0 and code 0xFF sets bit 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; loads midscale |
| ser_clk | input | 1 | Serial clock; bits are taken on its rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_sel | input | 1 | Select, high during a frame; its falling edge commits |
| wiper_code | output | 8 | Current wiper register value |
| tap_sel | output | 256 | One-hot ladder tap select decoded from the wiper code |
| wiper_update | output | 1 | One-cycle pulse in the cycle the wiper register takes a new word |

## Verification
The assertions assume the serial inputs change slowly compared with the system clock. Each serial clock phase, and the low time of select, must last at least two system cycles. With that margin the synchronized select is still low one cycle after a commit. The bench drives the serial clock with three system cycles per phase. It also waits several cycles between a select edge and the nearest serial clock edge. The same clock is sampled into a queue-based reference model. That model compares the wiper code, tap select and update pulse against the design on every cycle.

// File: rtl/hsel_wiper_ctrl.sv
module hsel_wiper_ctrl #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RESET_CODE  = 1 << (WIDTH - 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ser_clk,
  input  logic                    ser_dat,
  input  logic                    ser_sel,
  output logic [WIDTH-1:0]        wiper_code,
  output logic [(1<<WIDTH)-1:0]   tap_sel,
  output logic                    wiper_update
);
  localparam int TAPS = 1 << WIDTH;
  localparam int CW   = $clog2(WIDTH + 1);

  logic [SYNC_STAGES-1:0] clk_pipe, dat_pipe, sel_pipe;
  logic                   clk_s, dat_s, sel_s;
  logic                   clk_q, sel_q;
  logic [WIDTH-1:0]       shreg, wiper_q;
  logic [CW-1:0]          bit_cnt;
  logic                   upd_q;
  logic                   shift_en, sel_fall, frame_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_pipe <= '0;
      dat_pipe <= '0;
      sel_pipe <= '0;
    end else begin
      clk_pipe <= {clk_pipe[SYNC_STAGES-2:0], ser_clk};
      dat_pipe <= {dat_pipe[SYNC_STAGES-2:0], ser_dat};
      sel_pipe <= {sel_pipe[SYNC_STAGES-2:0], ser_sel};
    end
  end

  assign clk_s = clk_pipe[SYNC_STAGES-1];
  assign dat_s = dat_pipe[SYNC_STAGES-1];
  assign sel_s = sel_pipe[SYNC_STAGES-1];

  assign shift_en   = sel_s & clk_s & ~clk_q;
  assign sel_fall   = sel_q & ~sel_s;
  assign frame_full = (bit_cnt == CW'(WIDTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q   <= 1'b0;
      sel_q   <= 1'b0;
      shreg   <= '0;
      bit_cnt <= '0;
      wiper_q <= WIDTH'(RESET_CODE);
      upd_q   <= 1'b0;
    end else begin
      clk_q <= clk_s;
      sel_q <= sel_s;
      upd_q <= 1'b0;
      if (sel_fall) begin
        bit_cnt <= '0;
        if (frame_full) begin
          wiper_q <= shreg;
          upd_q   <= 1'b1;
        end
      end else if (shift_en) begin
        shreg <= {shreg[WIDTH-2:0], dat_s};
        if (!frame_full) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign wiper_code   = wiper_q;
  assign wiper_update = upd_q;

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign tap_sel[i] = (wiper_q == WIDTH'(i));
  end
endmodule

// File: rtl/hsel_wiper_ctrl_chk.sv
module hsel_wiper_ctrl_chk #(
  parameter int WIDTH      = 8,
  parameter int RESET_CODE = 1 << (WIDTH - 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [WIDTH-1:0]      wiper_code,
  input logic [(1<<WIDTH)-1:0] tap_sel,
  input logic                  wiper_update,
  input logic                  sel_q
);
  // R1
  reset_mid_chk: assert property (@(posedge clk) !rst_n |=> (wiper_code == WIDTH'(RESET_CODE)));

  // R8
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $countones(tap_sel) == 1);

  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n) wiper_update |=> !wiper_update);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !wiper_update |-> $stable(wiper_code));

  // R3
  commit_sel_low_chk: assert property (@(posedge clk) disable iff (!rst_n) wiper_update |-> !sel_q);
endmodule

bind hsel_wiper_ctrl hsel_wiper_ctrl_chk #(.WIDTH(WIDTH), .RESET_CODE(RESET_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wiper_code(wiper_code), .tap_sel(tap_sel),
  .wiper_update(wiper_update), .sel_q(sel_q)
);

// File: tb/sim_hsel_wiper_ctrl.sv
module sim_hsel_wiper_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_sel = 1'b0;
  logic [7:0]   wiper_code;
  logic [255:0] tap_sel;
  logic         wiper_update;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hsel_wiper_ctrl u0 (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_sel(ser_sel), .wiper_code(wiper_code), .tap_sel(tap_sel), .wiper_update(wiper_update));

  // reference model: queue of input samples, behavioural frame handling
  bit hc[$], hd[$], hs[$];
  int m_wiper = 128, m_cnt = 0, m_sh = 0;
  bit m_upd = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hc = {0, 0, 0, 0}; hd = {0, 0, 0, 0}; hs = {0, 0, 0, 0};
      m_wiper = 128; m_cnt = 0; m_sh = 0; m_upd = 0;
    end else begin
      hc.push_front(ser_clk); hd.push_front(ser_dat); hs.push_front(ser_sel);
      void'(hc.pop_back()); void'(hd.pop_back()); void'(hs.pop_back());
      m_upd = 0;
      if (!hs[2] && hs[3]) begin
        if (m_cnt >= 8) begin m_wiper = m_sh; m_upd = 1; end
        m_cnt = 0;
      end else if (hs[2] && hc[2] && !hc[3]) begin
        m_sh = ((m_sh << 1) | hd[2]) & 255;
        m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (wiper_code !== 8'(m_wiper) || wiper_update !== m_upd ||
          tap_sel !== (256'd1 << m_wiper)) begin
        errors++;
        $display("FAIL R2/R7/R8 model: code=%h upd=%b exp code=%h upd=%b", wiper_code,
                 wiper_update, m_wiper, m_upd);
      end
      if (wiper_update) pulses++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] word, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_dat = word[i];
      wait_cyc(3); ser_clk = 1'b1;
      wait_cyc(3); ser_clk = 1'b0;
    end
  endtask

  task automatic frame(input logic [31:0] word, input int nbits);
    @(negedge clk); ser_sel = 1'b1;
    wait_cyc(4);
    send_bits(word, nbits);
    wait_cyc(3); ser_sel = 1'b0;
    wait_cyc(10);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    check("R1 code", wiper_code, 8'h80);
    check("R1 tap", tap_sel[128], 1);
    check("R1 tapcount", $countones(tap_sel), 1);
    check("R1 upd", wiper_update, 0);

    frame(32'h5A, 8);
    check("R2 word 5A", wiper_code, 8'h5A);
    check("R7 pulses", pulses, 1);

    @(negedge clk); ser_sel = 1'b1; wait_cyc(4);
    send_bits(32'hC3, 8);
    wait_cyc(8);
    check("R3 held while select high", wiper_code, 8'h5A);
    ser_sel = 1'b0; wait_cyc(10);
    check("R3 commit after fall", wiper_code, 8'hC3);

    frame(32'h50F, 11);
    check("R4 last eight kept", wiper_code, 8'h0F);

    frame(32'h15, 5);
    check("R5 short frame ignored", wiper_code, 8'h0F);
    check("R5 no pulse", pulses, 3);

    send_bits(32'hFF, 8);
    wait_cyc(6);
    check("R6 select-low clocks", wiper_code, 8'h0F);
    frame(32'h1B, 5);
    check("R6 no carried count", wiper_code, 8'h0F);
    check("R6 no pulse", pulses, 3);

    frame(32'h00, 8);
    check("R8 tap bit0", tap_sel[0], 1);
    check("R8 zero code", wiper_code, 0);
    frame(32'hFF, 8);
    check("R8 tap bit255", tap_sel[255], 1);
    check("R8 one hot", $countones(tap_sel), 1);
    check("R7 pulse per commit", pulses, 5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule